// File: doc/BRIEF.md
# Strap-Latched Clock Gating Controller

This block sits between a set of free-running source clocks and the clock groups a board needs: two low-voltage CPU copies, one high-voltage CPU copy, a bank of memory clocks, a bank of peripheral-bus clocks, fixed 24 MHz and 48 MHz clocks, and reference clocks. It decides, group by group, whether each clock toggles, is parked low, or is floated. It does no frequency synthesis; the source clocks arrive already generated.

While the power-on reset is held, four configuration pins are sampled on the CPU source clock. Three of them form a frequency code and one chooses how the peripheral-bus clock is made. After reset these values are frozen. The bus clock is either the CPU clock halved by a flop that starts together with the captured configuration, or a separate asynchronous 32 MHz source. Two active-low run controls then gate the groups. One stops only the low-voltage CPU copies. The other powers everything down. Each gate is a latch-based cell behind a two-stage synchronizer in the clock domain it controls, so every stop and restart happens on whole clock phases. The CPU source must be running during reset so that the configuration can be sampled.

Top module: `clkgate_ctrl`

## Requirements
- R1: The frequency code and the bus-mode bit are sampled on CPU source edges while reset is asserted. Changes on those pins after reset has been released have no effect on output enables or clock behaviour.
- R2: When the captured frequency code is 3'b111, every bit of `grp_oe` is 0 and every clock output stays at 0.
- R3: With `pwr_dn_n` high and `cpu_stop_n` low, the `cpul_clk` outputs are held at 0. The `cpuh_clk`, `sdram_clk`, `bus_clk`, `clk24`, `clk48` and `ref_clk` outputs keep toggling.
- R4: With `pwr_dn_n` low, every clock output is held at 0, whatever the level of `cpu_stop_n`.
- R5: A gated CPU output only changes level at the same instant as its source. Every high pulse is a full source high phase (4 ns at 125 MHz), and no low pulse is shorter than a source low phase.
- R6: With the captured bus-mode bit at 1, `bus_clk` runs at exactly half the CPU rate, and each of its rising edges coincides with a CPU source rising edge.
- R7: With the captured bus-mode bit at 0, `bus_clk` follows `src_bus32_clk`.
- R8: For frequency codes 3'b000 to 3'b110, with both run controls high, all seven bits of `grp_oe` are 1 and every group toggles at its source rate.
- R9: A change on a run control reaches a CPU group after exactly two further CPU source rising edges. After a stop, two more high pulses appear before the output parks low. After a release, the output resumes on the third rising edge.
- R10: While reset is asserted, all clock outputs are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| src_cpu_clk | input | 1 | CPU-rate source clock |
| src_bus32_clk | input | 1 | Asynchronous 32 MHz bus source |
| src_24_clk | input | 1 | Fixed 24 MHz source |
| src_48_clk | input | 1 | Fixed 48 MHz source |
| src_ref_clk | input | 1 | Reference-rate source |
| strap_fs | input | 3 | Frequency code configuration pins |
| strap_bsel | input | 1 | Bus-mode configuration pin (1 = half CPU rate) |
| cpu_stop_n | input | 1 | Active-low stop for the low-voltage CPU copies |
| pwr_dn_n | input | 1 | Active-low power-down for all groups |
| cpul_clk | output | N_CPUL | Low-voltage CPU clock copies |
| cpuh_clk | output | 1 | High-voltage CPU clock copy |
| sdram_clk | output | N_SDRAM | Memory clock copies at CPU rate |
| bus_clk | output | N_BUS | Peripheral-bus clock copies |
| clk24 | output | 1 | Gated 24 MHz clock |
| clk48 | output | 1 | Gated 48 MHz clock |
| ref_clk | output | N_REF | Gated reference clock copies |
| grp_oe | output | 7 | Per-group output enable (bit order: cpul, cpuh, sdram, bus, 24, 48, ref) |

## Verification
A wrong captured configuration shows in the first measurement window after reset: the enables drop, or the bus edge count is near 16 instead of 32 per 64 CPU cycles. A bad synchronizer or gate shows in the edge count taken in the ten cycles after a run control moves, where the count comes out other than 2 or 8. A gate that updates during the high phase produces a truncated pulse, which the pulse-width monitor reports at that edge. A divider that starts on the wrong phase produces a bus rising edge that does not line up with a CPU rising edge, which is reported at the first such edge.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
  localparam int unsigned GRP_CPUL  = 0;
  localparam int unsigned GRP_CPUH  = 1;
  localparam int unsigned GRP_SDRAM = 2;
  localparam int unsigned GRP_BUS   = 3;
  localparam int unsigned GRP_F24   = 4;
  localparam int unsigned GRP_F48   = 5;
  localparam int unsigned GRP_REF   = 6;
  localparam int unsigned NGRP      = 7;

  localparam int unsigned FS_W = 3;
  localparam logic [FS_W-1:0] FS_TRISTATE = '1;

  typedef struct packed {
    logic [FS_W-1:0] fs;
    logic            bsel;
  } strap_t;
endpackage

// File: rtl/clkgate_sync.sv
module clkgate_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], d_i};

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/clkgate_icg.sv
module clkgate_icg #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic en_req_i,
  output logic clk_o
);
  logic en_s;
  logic en_lat;

  clkgate_sync #(.STAGES(STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_n (rst_n),
    .d_i   (en_req_i),
    .q_o   (en_s)
  );

  // transparent only while the source is low: enable can never cut a high phase
  always_latch begin
    if (!clk_i) en_lat = en_s;
  end

  assign clk_o = clk_i & en_lat;
endmodule

// File: rtl/clkgate_strap.sv
module clkgate_strap
  import clkgate_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_n,
  input  logic [FS_W-1:0] fs_i,
  input  logic            bsel_i,
  output strap_t          strap_o,
  output logic            rst_sync_n_o,
  output logic            div2_o
);
  logic [1:0] rs_q, rs_d;
  strap_t     strap_q, strap_d;
  logic       div_q, div_d, div_en;

  // reset release synchronized to the CPU source
  always_comb rs_d = {rs_q[0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= rs_d;
  end

  // pins are followed while reset is held, frozen once it is released
  always_comb begin
    strap_d = strap_q;
    if (!rs_q[1]) strap_d = '{fs: fs_i, bsel: bsel_i};
  end

  always_ff @(posedge clk_i) strap_q <= strap_d;

  // half-rate bus clock, released on the same edge as the strap freeze
  always_comb begin
    div_en = rs_q[1];
    div_d  = ~div_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)      div_q <= 1'b0;
    else if (div_en) div_q <= div_d;
  end

  assign strap_o      = strap_q;
  assign rst_sync_n_o = rs_q[1];
  assign div2_o       = div_q;
endmodule

// File: rtl/clkgate_ctrl.sv
module clkgate_ctrl
  import clkgate_pkg::*;
#(
  parameter int N_CPUL      = 2,
  parameter int N_SDRAM     = 12,
  parameter int N_BUS       = 6,
  parameter int N_REF       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               rst_n,
  input  logic               src_cpu_clk,
  input  logic               src_bus32_clk,
  input  logic               src_24_clk,
  input  logic               src_48_clk,
  input  logic               src_ref_clk,
  input  logic [2:0]         strap_fs,
  input  logic               strap_bsel,
  input  logic               cpu_stop_n,
  input  logic               pwr_dn_n,
  output logic [N_CPUL-1:0]  cpul_clk,
  output logic               cpuh_clk,
  output logic [N_SDRAM-1:0] sdram_clk,
  output logic [N_BUS-1:0]   bus_clk,
  output logic               clk24,
  output logic               clk48,
  output logic [N_REF-1:0]   ref_clk,
  output logic [6:0]         grp_oe
);
  strap_t          straps;
  logic            rst_sync_n;
  logic            div2_clk;
  logic [FS_W-1:0] fs_q;
  logic            bsel_q;
  logic            tristate;
  logic [NGRP-1:0] src_clk;
  logic [NGRP-1:0] en_req;
  logic [NGRP-1:0] gclk;

  clkgate_strap u_strap (
    .clk_i        (src_cpu_clk),
    .rst_n        (rst_n),
    .fs_i         (strap_fs),
    .bsel_i       (strap_bsel),
    .strap_o      (straps),
    .rst_sync_n_o (rst_sync_n),
    .div2_o       (div2_clk)
  );

  assign fs_q     = straps.fs;
  assign bsel_q   = straps.bsel;
  assign tristate = (fs_q == FS_TRISTATE);

  always_comb begin
    src_clk[GRP_CPUL]  = src_cpu_clk;
    src_clk[GRP_CPUH]  = src_cpu_clk;
    src_clk[GRP_SDRAM] = src_cpu_clk;
    src_clk[GRP_BUS]   = bsel_q ? div2_clk : src_bus32_clk;
    src_clk[GRP_F24]   = src_24_clk;
    src_clk[GRP_F48]   = src_48_clk;
    src_clk[GRP_REF]   = src_ref_clk;
  end

  generate
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
      if (g == GRP_CPUL) begin : g_stoppable
        assign en_req[g] = pwr_dn_n & ~tristate & cpu_stop_n;
      end else begin : g_free
        assign en_req[g] = pwr_dn_n & ~tristate;
      end

      clkgate_icg #(.STAGES(SYNC_STAGES)) u_icg (
        .clk_i    (src_clk[g]),
        .rst_n    (rst_n),
        .en_req_i (en_req[g]),
        .clk_o    (gclk[g])
      );
    end
  endgenerate

  assign cpul_clk  = {N_CPUL{gclk[GRP_CPUL]}};
  assign cpuh_clk  = gclk[GRP_CPUH];
  assign sdram_clk = {N_SDRAM{gclk[GRP_SDRAM]}};
  assign bus_clk   = {N_BUS{gclk[GRP_BUS]}};
  assign clk24     = gclk[GRP_F24];
  assign clk48     = gclk[GRP_F48];
  assign ref_clk   = {N_REF{gclk[GRP_REF]}};
  assign grp_oe    = {NGRP{~tristate}};
endmodule

// File: rtl/clkgate_ctrl_chk.sv
module clkgate_ctrl_chk (
  input logic       rst_n,
  input logic       rst_sync_n,
  input logic       src_cpu_clk,
  input logic       cpu_stop_n,
  input logic       pwr_dn_n,
  input logic [2:0] fs_q,
  input logic       bsel_q,
  input logic       cpul0,
  input logic       sdram0,
  input logic       bus0,
  input logic [6:0] grp_oe
);
  logic [3:0] pd_hi_cnt, pd_lo_cnt, stop_lo_cnt;

  always_ff @(negedge src_cpu_clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_hi_cnt   <= '0;
      pd_lo_cnt   <= '0;
      stop_lo_cnt <= '0;
    end else begin
      pd_hi_cnt   <= !pwr_dn_n   ? 4'd0 : (pd_hi_cnt == 4'd15 ? pd_hi_cnt : pd_hi_cnt + 4'd1);
      pd_lo_cnt   <= pwr_dn_n    ? 4'd0 : (pd_lo_cnt == 4'd15 ? pd_lo_cnt : pd_lo_cnt + 4'd1);
      stop_lo_cnt <= cpu_stop_n  ? 4'd0 : (stop_lo_cnt == 4'd15 ? stop_lo_cnt : stop_lo_cnt + 4'd1);
    end
  end

  a_r1_strap_frozen: assert property (@(posedge src_cpu_clk) disable iff (!rst_sync_n)
    $past(rst_sync_n) |-> $stable({fs_q, bsel_q}));

  a_r2_tristate_oe: assert property (@(posedge src_cpu_clk) disable iff (!rst_sync_n)
    (fs_q == 3'b111) |-> (grp_oe == 7'h00));

  a_r2_tristate_quiet: assert property (@(negedge src_cpu_clk) disable iff (!rst_sync_n)
    (fs_q == 3'b111) |-> (!cpul0 && !sdram0 && !bus0));

  a_r4_powerdown: assert property (@(negedge src_cpu_clk) disable iff (!rst_sync_n)
    (pd_lo_cnt >= 4'd4) |-> (!cpul0 && !sdram0));

  a_r3_cpu_stopped: assert property (@(negedge src_cpu_clk) disable iff (!rst_sync_n)
    (stop_lo_cnt >= 4'd4) |-> !cpul0);

  a_r3_sdram_runs: assert property (@(negedge src_cpu_clk) disable iff (!rst_sync_n)
    (stop_lo_cnt >= 4'd4 && pd_hi_cnt >= 4'd4 && fs_q != 3'b111) |-> sdram0);

  a_r6_bus_half: assert property (@(negedge src_cpu_clk) disable iff (!rst_sync_n)
    (bsel_q && fs_q != 3'b111 && pd_hi_cnt >= 4'd12) |-> (bus0 != $past(bus0)));

  // R5: the gated copy may only move together with its source
  always @(cpul0) begin
    if (rst_sync_n) begin
      a_r5_glitch_free: assert (cpul0 == src_cpu_clk);
    end
  end
endmodule

bind clkgate_ctrl clkgate_ctrl_chk u_chk (
  .rst_n       (rst_n),
  .rst_sync_n  (rst_sync_n),
  .src_cpu_clk (src_cpu_clk),
  .cpu_stop_n  (cpu_stop_n),
  .pwr_dn_n    (pwr_dn_n),
  .fs_q        (fs_q),
  .bsel_q      (bsel_q),
  .cpul0       (cpul_clk[0]),
  .sdram0      (sdram_clk[0]),
  .bus0        (bus_clk[0]),
  .grp_oe      (grp_oe)
);

// File: tb/clkgate_ctrl_tb_top.sv
`timescale 1ns/1ps
module clkgate_ctrl_tb_top;
  localparam int N_CPUL = 2, N_SDRAM = 12, N_BUS = 6, N_REF = 2;
  localparam int M_CPUL = 0, M_CPUH = 1, M_SDRAM = 2, M_BUS = 3, M_F24 = 4,
                 M_F48 = 5, M_REF = 6, M_OE = 7, M_FAULT = 8, M_MISAL = 9, M_CPUL1 = 10;

  logic rst_n = 1'b0;
  logic cpu_clk = 1'b0, bus32 = 1'b0, c24 = 1'b0, c48 = 1'b0, cref = 1'b0;
  logic [2:0] fs = 3'b000;
  logic bsel = 1'b1;
  logic stop_n = 1'b1, pd_n = 1'b1;
  logic [N_CPUL-1:0] cpul;
  logic cpuh;
  logic [N_SDRAM-1:0] sdram;
  logic [N_BUS-1:0] bus;
  logic o24, o48;
  logic [N_REF-1:0] oref;
  logic [6:0] oe;

  int checks = 0, failures = 0;
  bit done = 0;
  bit exp_bsel = 1'b1;

  always #4        cpu_clk = ~cpu_clk;
  always #15.625   bus32 = ~bus32;
  always #20.8333  c24 = ~c24;
  always #10.4167  c48 = ~c48;
  always #34.9206  cref = ~cref;

  clkgate_ctrl dut_i (
    .rst_n(rst_n), .src_cpu_clk(cpu_clk), .src_bus32_clk(bus32), .src_24_clk(c24),
    .src_48_clk(c48), .src_ref_clk(cref), .strap_fs(fs), .strap_bsel(bsel),
    .cpu_stop_n(stop_n), .pwr_dn_n(pd_n), .cpul_clk(cpul), .cpuh_clk(cpuh),
    .sdram_clk(sdram), .bus_clk(bus), .clk24(o24), .clk48(o48), .ref_clk(oref),
    .grp_oe(oe)
  );

  // edge counters, each owned by one process
  int n_cpul = 0, n_cpul1 = 0, n_cpuh = 0, n_sdram = 0, n_bus = 0, n_24 = 0, n_48 = 0, n_ref = 0;
  int n_fault = 0, n_misal = 0;
  always @(posedge cpul[0])         n_cpul++;
  always @(posedge cpul[N_CPUL-1])  n_cpul1++;
  always @(posedge cpuh)            n_cpuh++;
  always @(posedge sdram[0])        n_sdram++;
  always @(posedge bus[N_BUS-1])    n_bus++;
  always @(posedge o24)             n_24++;
  always @(posedge o48)             n_48++;
  always @(posedge oref[0])         n_ref++;

  // R5 pulse-width monitor on a CPU-low copy
  realtime t_rise = -1.0, t_fall = -1.0;
  always @(cpul[0]) begin
    if (cpul[0]) begin
      if (t_fall >= 0.0 && ($realtime - t_fall) < 3.99) n_fault++;
      t_rise = $realtime;
    end else begin
      if (t_rise >= 0.0 && (($realtime - t_rise) < 3.99 || ($realtime - t_rise) > 4.01)) n_fault++;
      t_fall = $realtime;
    end
  end

  // R6 alignment monitor: CPU rises fall at 4 ns mod 8 ns
  always @(posedge bus[0]) begin
    if (exp_bsel) begin
      longint ps;
      ps = longint'($realtime * 1000.0);
      if (ps % 8000 != 4000) n_misal++;
    end
  end

  function automatic int raw(int id);
    case (id)
      M_CPUL:  return n_cpul;
      M_CPUL1: return n_cpul1;
      M_CPUH:  return n_cpuh;
      M_SDRAM: return n_sdram;
      M_BUS:   return n_bus;
      M_F24:   return n_24;
      M_F48:   return n_48;
      M_REF:   return n_ref;
      M_OE:    return int'(oe);
      M_FAULT: return n_fault;
      M_MISAL: return n_misal;
      default: return 0;
    endcase
  endfunction

  // scoreboard
  typedef struct {
    string req;
    int    id;
    int    lo;
    int    hi;
  } exp_t;
  exp_t exp_q[$];
  int   snap[11];
  int   meas[11];

  task automatic push(string req, int id, int lo, int hi);
    exp_t e;
    e.req = req; e.id = id; e.lo = lo; e.hi = hi;
    exp_q.push_back(e);
  endtask

  task automatic take_snap();
    for (int i = 0; i < 11; i++) snap[i] = raw(i);
  endtask

  task automatic take_delta();
    for (int i = 0; i < 11; i++)
      meas[i] = (i == M_OE || i == M_FAULT || i == M_MISAL) ? raw(i) : raw(i) - snap[i];
  endtask

  task automatic window(int n);
    @(negedge cpu_clk);
    take_snap();
    repeat (n) @(negedge cpu_clk);
    take_delta();
  endtask

  task automatic drain();
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (meas[e.id] < e.lo || meas[e.id] > e.hi) begin
        failures++;
        $display("FAIL %s metric %0d actual=%0d expected=%0d..%0d", e.req, e.id, meas[e.id], e.lo, e.hi);
      end
    end
  endtask

  task automatic do_reset(logic [2:0] f, logic b);
    @(negedge cpu_clk); #1;
    rst_n = 1'b0; fs = f; bsel = b; exp_bsel = 1'b0;
    repeat (8) @(negedge cpu_clk);
    // R10: quiet while reset is held
    push("R10", M_CPUL, 0, 0); push("R10", M_SDRAM, 0, 0);
    push("R10", M_BUS, 0, 0);  push("R10", M_REF, 0, 0);
    window(16);
    drain();
    #1 rst_n = 1'b1;
    exp_bsel = b;
    repeat (60) @(negedge cpu_clk);
  endtask

  task automatic push_running(string req, bit b);
    push(req, M_CPUL, 64, 64); push(req, M_CPUL1, 64, 64);
    push(req, M_CPUH, 64, 64); push(req, M_SDRAM, 64, 64);
    if (b) push(req, M_BUS, 32, 32); else push(req, M_BUS, 14, 19);
    push(req, M_F24, 11, 14); push(req, M_F48, 23, 26); push(req, M_REF, 6, 9);
    push(req, M_OE, 127, 127);
  endtask

  initial begin
    // every strap combination
    for (int code = 0; code < 8; code++) begin
      for (int b = 0; b < 2; b++) begin
        do_reset(code[2:0], b[0]);
        if (code == 7) begin
          push("R2", M_OE, 0, 0);   push("R2", M_CPUL, 0, 0); push("R2", M_CPUH, 0, 0);
          push("R2", M_SDRAM, 0, 0); push("R2", M_BUS, 0, 0); push("R2", M_F24, 0, 0);
          push("R2", M_F48, 0, 0);  push("R2", M_REF, 0, 0);
        end else if (b == 1) begin
          push_running("R8_R6", 1'b1);
        end else begin
          push_running("R8_R7", 1'b0);
        end
        window(64);
        drain();
      end
    end

    // R1: strap pins moved after reset do nothing
    do_reset(3'b001, 1'b0);
    fs = 3'b111; bsel = 1'b1;
    repeat (20) @(negedge cpu_clk);
    push("R1", M_OE, 127, 127); push("R1", M_BUS, 14, 19); push("R1", M_CPUL, 64, 64);
    window(64);
    drain();

    // R3: CPU-low stopped alone
    do_reset(3'b000, 1'b1);
    @(posedge cpu_clk); #2 stop_n = 1'b0;
    repeat (10) @(negedge cpu_clk);
    push("R3", M_CPUL, 0, 0); push("R3", M_CPUH, 64, 64); push("R3", M_SDRAM, 64, 64);
    push("R3", M_BUS, 32, 32); push("R3", M_F24, 11, 14); push("R3", M_F48, 23, 26);
    push("R3", M_REF, 6, 9);
    window(64);
    drain();
    @(posedge cpu_clk); #1.5 stop_n = 1'b1;
    repeat (10) @(negedge cpu_clk);
    push("R5", M_CPUL, 64, 64);
    window(64);
    drain();

    // R9: stop and release latency counted in CPU rising edges
    @(negedge cpu_clk); #1 stop_n = 1'b0;
    take_snap(); repeat (10) @(negedge cpu_clk); take_delta();
    push("R9", M_CPUL, 2, 2); drain();
    @(negedge cpu_clk); #1 stop_n = 1'b1;
    take_snap(); repeat (10) @(negedge cpu_clk); take_delta();
    push("R9", M_CPUL, 8, 8); drain();
    @(negedge cpu_clk); #1 pd_n = 1'b0;
    take_snap(); repeat (10) @(negedge cpu_clk); take_delta();
    push("R9", M_SDRAM, 2, 2); drain();
    @(negedge cpu_clk); #1 pd_n = 1'b1;
    take_snap(); repeat (10) @(negedge cpu_clk); take_delta();
    push("R9", M_CPUH, 8, 8); drain();

    // R5: stop toggled at many phases
    for (int i = 0; i < 40; i++) begin
      @(posedge cpu_clk);
      #(0.5 + (i % 7) * 1.1) stop_n = ~stop_n;
      repeat (i % 3 + 1) @(posedge cpu_clk);
    end
    stop_n = 1'b1;
    repeat (10) @(negedge cpu_clk);
    push("R5", M_FAULT, 0, 0); push("R6", M_MISAL, 0, 0);
    window(8);
    drain();

    // R4: power-down overrides, stop high then low
    @(negedge cpu_clk); #1 pd_n = 1'b0;
    repeat (40) @(negedge cpu_clk);
    push("R4", M_CPUL, 0, 0); push("R4", M_CPUH, 0, 0); push("R4", M_SDRAM, 0, 0);
    push("R4", M_BUS, 0, 0);  push("R4", M_F24, 0, 0);  push("R4", M_F48, 0, 0);
    push("R4", M_REF, 0, 0);
    window(64);
    drain();
    stop_n = 1'b0;
    repeat (10) @(negedge cpu_clk);
    push("R4", M_CPUL, 0, 0); push("R4", M_SDRAM, 0, 0); push("R4", M_REF, 0, 0);
    window(64);
    drain();
    pd_n = 1'b1; stop_n = 1'b1;
    repeat (40) @(negedge cpu_clk);
    push("R5", M_FAULT, 0, 0);
    window(8);
    drain();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  int cyc = 0;
  always @(posedge cpu_clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d cycles expected=completion", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule